// File: doc/BRIEF.md
# Fast Ethernet Transmit Line Encoder

This block turns the 4-bit transmit nibble stream of a 100 Mb/s MAC into the three-level symbol stream a twisted-pair line driver needs. Each nibble becomes a 5-bit code group. Frame boundaries are marked with start and end delimiter groups. The group bits are sent one per bit time and whitened with an 11-bit maximal-length keystream. They then pass through an NRZI stage and a three-level (MLT3) level sequencer. The result is a signed level of -1, 0 or +1 for an external driver.

A single clock runs the block. The input `bit_en` is high for one cycle in every 125 MHz bit period. The block fetches a new nibble once every five bit periods and pulses `nib_strobe` in that cycle. The MAC side therefore presents `tx_en` and `txd` before that strobe and steps to its next nibble after it.

Top module: `fe_tx_encoder`

## Requirements
- R1: After reset `line_lvl` is 0 and the scrambler state is all ones. The first code group sent, before any nibble is fetched, is IDLE (11111).
- R2: `nib_strobe` is high only in a cycle where `bit_en` is high, and exactly once every five `bit_en` cycles, at the fifth. `txd` and `tx_en` are sampled in that cycle. The resulting group is sent MSB first over the next five bit periods.
- R3: Data nibbles 0..F map to 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101.
- R4: A fetch with `tx_en` low outside a frame end produces IDLE (11111).
- R5: The first fetch with `tx_en` high after idle sends J (11000). The next fetch always sends K (10001), in place of those two nibbles.
- R6: The first fetch with `tx_en` low after a frame sends T (01101). The next fetch always sends R (00111). Frames hold at least two nibbles and gaps at least two.
- R7: In each bit period the keystream bit is k = s[10] XOR s[8] of the state s, and s shifts left taking k into bit 0 (polynomial x^11 + x^9 + 1). The sent bit is the group bit XOR k.
- R8: The scrambled bit drives an NRZI toggle. Each toggle moves `line_lvl` one step along 0, +1, 0, -1, and a hold leaves it unchanged. `line_lvl` is two's complement: 01 = +1, 11 = -1, 00 = 0.
- R9: In a cycle with `bit_en` low, `line_lvl` and the nibble phase do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One pulse per 125 MHz bit period |
| tx_en | input | 1 | Frame-active flag for the current nibble |
| txd | input | 4 | Transmit nibble |
| nib_strobe | output | 1 | Nibble fetch in this cycle |
| line_lvl | output | 2 | Signed line level -1/0/+1 |

## Verification
Two things can fall on the same nibble fetch: a `tx_en` edge and the delimiter substitution it triggers. The end of a delimiter pair can also coincide with the next data nibble. The bench moves `tx_en` exactly on strobe edges and runs frames of two nibbles and of many nibbles. It also thins `bit_en` with regular gaps, so that fetches land on stretched bit periods. A reference chain undoes the MLT3, NRZI and scrambling stages and regroups the bits into 5-bit groups. Each group is compared against the delimiter, idle or data code expected for that fetch. The run continues past the 2047-bit keystream period.

// File: rtl/fe_tx_encoder.sv
module fe_tx_encoder #(
  parameter int SCR_W = 11,
  parameter int SCR_TAP = 8,
  parameter logic [SCR_W-1:0] SCR_SEED = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              tx_en,
  input  logic [3:0]        txd,
  output logic              nib_strobe,
  output logic signed [1:0] line_lvl
);
  localparam logic [4:0] CG_IDLE = 5'b11111;
  localparam logic [4:0] CG_J    = 5'b11000;
  localparam logic [4:0] CG_K    = 5'b10001;
  localparam logic [4:0] CG_T    = 5'b01101;
  localparam logic [4:0] CG_R    = 5'b00111;

  typedef enum logic [1:0] {FS_IDLE, FS_K, FS_DATA, FS_R} fstate_t;

  function automatic logic [4:0] enc4b5b(input logic [3:0] n);
    case (n)
      4'h0: return 5'b11110;  4'h1: return 5'b01001;
      4'h2: return 5'b10100;  4'h3: return 5'b10101;
      4'h4: return 5'b01010;  4'h5: return 5'b01011;
      4'h6: return 5'b01110;  4'h7: return 5'b01111;
      4'h8: return 5'b10010;  4'h9: return 5'b10011;
      4'hA: return 5'b10110;  4'hB: return 5'b10111;
      4'hC: return 5'b11010;  4'hD: return 5'b11011;
      4'hE: return 5'b11100;  default: return 5'b11101;
    endcase
  endfunction

  fstate_t          fs, fs_n;
  logic [2:0]       cnt;
  logic [4:0]       grp, code;
  logic [SCR_W-1:0] lfsr;
  logic             nrzi;
  logic [1:0]       phase;

  wire kbit    = lfsr[SCR_W-1] ^ lfsr[SCR_TAP];
  wire sbit    = grp[4] ^ kbit;
  wire nrzi_nx = nrzi ^ sbit;
  wire step    = nrzi_nx ^ nrzi;

  assign nib_strobe = bit_en && (cnt == 3'd4);
  assign line_lvl   = (phase == 2'd1) ? 2'sb01 : (phase == 2'd3) ? 2'sb11 : 2'sb00;

  always_comb begin
    code = CG_IDLE;
    fs_n = fs;
    case (fs)
      FS_IDLE: if (tx_en) begin code = CG_J; fs_n = FS_K; end
      FS_K:    begin code = CG_K; fs_n = FS_DATA; end
      FS_DATA: if (tx_en) code = enc4b5b(txd);
               else begin code = CG_T; fs_n = FS_R; end
      default: begin code = CG_R; fs_n = FS_IDLE; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fs    <= FS_IDLE;
      cnt   <= 3'd0;
      grp   <= CG_IDLE;
      lfsr  <= SCR_SEED;
      nrzi  <= 1'b0;
      phase <= 2'd0;
    end else if (bit_en) begin
      lfsr <= {lfsr[SCR_W-2:0], kbit};
      nrzi <= nrzi_nx;
      if (step) phase <= phase + 2'd1;
      if (cnt == 3'd4) begin
        cnt <= 3'd0;
        grp <= code;
        fs  <= fs_n;
      end else begin
        cnt <= cnt + 3'd1;
        grp <= {grp[3:0], 1'b0};
      end
    end
  end

  AST_HOLD_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(line_lvl)); // R9
  AST_ZERO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !sbit) |=> $stable(line_lvl)); // R8
  AST_ONE_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && sbit) |=> !$stable(line_lvl)); // R8
  AST_NO_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
    (line_lvl == 2'sb01) |=> (line_lvl != 2'sb11)); // R8
  AST_STROBE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    nib_strobe |=> !nib_strobe); // R2
  AST_SCR_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != '0); // R7
endmodule

// File: tb/tb_fe_tx_encoder.sv
module tb_fe_tx_encoder;
  localparam int CLK_PERIOD = 8;
  localparam int MAXS = 700;

  logic clk = 0, rst_n = 0, bit_en = 0, tx_en = 0;
  logic [3:0] txd = 0;
  logic nib_strobe;
  logic signed [1:0] line_lvl;

  fe_tx_encoder dut (.clk(clk), .rst_n(rst_n), .bit_en(bit_en), .tx_en(tx_en),
                     .txd(txd), .nib_strobe(nib_strobe), .line_lvl(line_lvl));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, nslots = 0;
  logic st_en [MAXS];
  logic [3:0] st_d [MAXS];
  bit done = 0;

  function automatic logic [4:0] ref_code(input logic [3:0] n);
    logic [4:0] t [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101, 5'b01010, 5'b01011,
                           5'b01110, 5'b01111, 5'b10010, 5'b10011, 5'b10110, 5'b10111,
                           5'b11010, 5'b11011, 5'b11100, 5'b11101};
    return t[n];
  endfunction

  function automatic logic en_at(input int i);
    if (i < 0 || i >= nslots) return 1'b0;
    return st_en[i];
  endfunction

  function automatic logic [4:0] exp_group(input int g);
    int i;
    if (g == 0) return 5'b11111;
    i = g - 1;
    if (en_at(i)) begin
      if (!en_at(i-1)) return 5'b11000;
      if (!en_at(i-2)) return 5'b10001;
      return ref_code(st_d[i]);
    end
    if (en_at(i-1)) return 5'b01101;
    if (en_at(i-2)) return 5'b00111;
    return 5'b11111;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic add(input logic e, input logic [3:0] d);
    st_en[nslots] = e; st_d[nslots] = d; nslots++;
  endtask

  // reference receive chain state
  logic [10:0] rx_lfsr = 11'h7FF;
  int prev_lvl = 0, last_nz = -1, nbits = 0, ngroups = 0;
  logic [4:0] rx_grp = 0;

  task automatic consume_bit();
    int lv, want;
    logic s, k, p;
    lv = int'(line_lvl);
    s = (lv != prev_lvl);
    if (s) begin
      want = (prev_lvl != 0) ? 0 : -last_nz;
      check(lv == want, "R8 level order", lv, want);
      if (lv != 0) last_nz = lv;
    end
    k = rx_lfsr[10] ^ rx_lfsr[8];
    rx_lfsr = {rx_lfsr[9:0], k};
    p = s ^ k;
    prev_lvl = lv;
    rx_grp = {rx_grp[3:0], p};
    nbits++;
    if (nbits % 5 == 0) begin
      logic [4:0] e;
      e = exp_group(ngroups);
      check(rx_grp == e, (ngroups == 0) ? "R1 first group" :
            (e == 5'b11000 || e == 5'b10001) ? "R5 start delimiter" :
            (e == 5'b01101 || e == 5'b00111) ? "R6 end delimiter" :
            (e == 5'b11111) ? "R4 idle" : "R3 data code R7", int'(rx_grp), int'(e));
      if (ngroups > 0 && en_at(ngroups-1) && en_at(ngroups-2) && en_at(ngroups-3)) begin
        int nib;
        nib = -1;
        for (int v = 0; v < 16; v++) if (ref_code(4'(v)) == rx_grp) nib = v;
        check(nib == int'(st_d[ngroups-1]), "R3 nibble recovered", nib, int'(st_d[ngroups-1]));
      end
      ngroups++;
    end
  endtask

  initial begin
    int slot, cyc, lv_before;
    for (int i = 0; i < 3; i++) add(0, 0);
    for (int i = 0; i < 18; i++) add(1, (i < 2) ? 4'h5 : 4'(i - 2));
    for (int i = 0; i < 3; i++) add(0, 0);
    add(1, 4'h5); add(1, 4'hD);
    for (int i = 0; i < 2; i++) add(0, 0);
    for (int i = 0; i < 42; i++) add(1, 4'((i * 7 + 3) % 16));
    for (int i = 0; i < 3; i++) add(0, 0);
    for (int f = 0; f < 16; f++) begin
      add(1, 4'h5); add(1, 4'h5); add(1, 4'(f)); add(1, 4'(15 - f));
      add(0, 0); add(0, 0);
    end
    for (int i = 0; i < 440; i++) add(0, 0);

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(line_lvl == 2'sb00, "R1 reset level", int'(line_lvl), 0);
    check(nib_strobe == 0, "R2 no strobe without bit_en", int'(nib_strobe), 0);

    slot = 0; cyc = 0;
    while (ngroups < nslots + 2) begin
      logic en, take;
      en = !(slot < 160 && cyc % 3 == 2);
      bit_en = en;
      tx_en = en_at(slot);
      txd = (slot < nslots) ? st_d[slot] : 4'h0;
      lv_before = int'(line_lvl);
      #1;
      take = nib_strobe;
      if (take) check(en && (nbits % 5 == 4), "R2 strobe phase", nbits % 5, 4);
      @(negedge clk);
      if (en) consume_bit();
      else check(int'(line_lvl) == lv_before, "R9 hold without bit_en", int'(line_lvl), lv_before);
      if (take) slot++;
      cyc++;
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", ngroups, nslots + 2);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule